// File: doc/BRIEF.md
# Speculative Branch Tag Tracker

This block keeps track of up to four conditional branches whose outcome is not yet known, and gives every instruction in a small issue window a dependency mask. Bit k of a mask means "issued while branch slot k was unresolved." A branch asks for a slot and is granted the lowest free one. Any instruction issued afterwards inherits the current set of active slots as its mask.

A resolution names a slot and states whether the branch was predicted correctly. On a correct outcome, that slot's bit is removed from every stored mask and the slot is freed, all in one edge. On a misprediction, every window entry carrying the bit is invalidated and flagged on a one-cycle abort vector, so its result is never written back. The mispredicted slot is freed, together with every younger branch slot that was allocated under it.

Top module: `spec_tag_tracker`

## Requirements
- R1: `active_mask_o` bit k is 1 exactly while branch slot k is allocated and unresolved; at most four slots (bits 0..3) exist.
- R2: A request on `br_req_i` with a free slot allocates the lowest-numbered free slot. In the following cycle `br_gnt_o` is 1, `br_slot_o` holds that slot number, and its bit is set in `active_mask_o`.
- R3: A request while all four slots are busy is refused: `br_gnt_o` is 0 in the following cycle and `active_mask_o` is unchanged.
- R4: An issue to window index i stores a mask equal to the active mask after that cycle's resolution. A slot allocated in the same cycle is not included. The entry becomes valid, and `rd_mask_o` returns the stored mask when `rd_idx_i` = i.
- R5: A correct resolution (`res_mispred_i`=0) of a busy slot s clears bit s in every stored mask and frees slot s at the same edge.
- R6: A misprediction (`res_mispred_i`=1) of a busy slot s invalidates every valid entry whose mask has bit s set. `abort_vec_o` bit i is 1 for exactly those entries, for exactly the one following cycle.
- R7: A misprediction of slot s also frees every busy slot whose allocation-time mask held bit s.
- R8: When a resolution and an allocation arrive in the same cycle, the resolution is applied first, so a slot it frees can be granted at once.
- R9: A resolution naming a slot that is not busy has no effect on any output.
- R10: After reset, there are no active slots, no valid entries, no grant and an all-zero abort vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_req_i | input | 1 | Branch slot allocation request |
| br_gnt_o | output | 1 | Grant, one cycle after the request |
| br_slot_o | output | 2 | Granted slot number, valid with the grant |
| issue_i | input | 1 | Instruction issue strobe |
| issue_idx_i | input | 3 | Window entry written on issue |
| res_valid_i | input | 1 | Branch resolution strobe |
| res_slot_i | input | 2 | Slot being resolved |
| res_mispred_i | input | 1 | 1 = mispredicted, 0 = correctly predicted |
| active_mask_o | output | 4 | Currently unresolved slots |
| abort_vec_o | output | 8 | Entries aborted by the last cycle's misprediction |
| entry_valid_o | output | 8 | Valid bit per window entry |
| rd_idx_i | input | 3 | Window entry to read |
| rd_mask_o | output | 4 | Stored mask of the entry selected by `rd_idx_i` |

## Verification
Some properties are checked on every cycle by the assertions:
- a refused request never yields a grant;
- a granted slot is always active;
- the abort vector is nonzero only right after a mispredict;
- no valid entry keeps a bit that was just resolved correctly;
- a mispredict frees every dependent slot.

Other behaviour can only be shown by the bench's scenarios. This covers the lowest-free choice, the exact masks inherited at issue, the ordering of a same-cycle resolve and allocate, and the lack of effect of resolving an idle slot. The bench shows these by comparing a behavioural model against the outputs on every clock, across directed and random traffic.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_WIN   = 8;
endpackage

// File: rtl/spec_slot_alloc.sv
module spec_slot_alloc #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [NUM_SLOTS-1:0] busy_post_i,
  output logic [NUM_SLOTS-1:0] oh_o,
  output logic                 gnt_o,
  output logic [SLOT_W-1:0]    slot_o
);
  logic              fire;
  logic [SLOT_W-1:0] pick;

  // descending scan: lowest free slot wins
  always_comb begin
    fire = 1'b0;
    pick = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (!busy_post_i[k]) begin
        fire = req_i;
        pick = SLOT_W'(k);
      end
    end
    oh_o = fire ? (NUM_SLOTS'(1) << pick) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o  <= 1'b0;
      slot_o <= '0;
    end else begin
      gnt_o <= fire;
      if (fire) slot_o <= pick;
    end
  end

  a_r3_full_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (&busy_post_i)) |=> !gnt_o);
endmodule

// File: rtl/spec_slot_table.sv
module spec_slot_table #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 res_valid_i,
  input  logic [SLOT_W-1:0]    res_slot_i,
  input  logic                 res_mispred_i,
  input  logic [NUM_SLOTS-1:0] alloc_oh_i,
  output logic [NUM_SLOTS-1:0] busy_o,
  output logic [NUM_SLOTS-1:0] busy_post_o,
  output logic [NUM_SLOTS-1:0] kill_o,
  output logic [NUM_SLOTS-1:0] res_bit_o,
  output logic                 res_hit_o
);
  logic [NUM_SLOTS-1:0] busy_q;
  logic [NUM_SLOTS-1:0] dep_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] dep_hit;

  assign res_bit_o = NUM_SLOTS'(1) << res_slot_i;
  assign res_hit_o = res_valid_i && |(busy_q & res_bit_o);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_dep
    assign dep_hit[k] = busy_q[k] && |(dep_q[k] & res_bit_o);
  end

  always_comb begin
    kill_o = '0;
    if (res_hit_o) kill_o = res_mispred_i ? (res_bit_o | dep_hit) : res_bit_o;
  end

  assign busy_post_o = busy_q & ~kill_o;
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_post_o | alloc_oh_i;
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            dep_q[k] <= '0;
      else if (alloc_oh_i[k]) dep_q[k] <= busy_post_o;
      else                    dep_q[k] <= dep_q[k] & ~kill_o;
    end
  end

  a_r7_dependents_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_hit_o && res_mispred_i) |=> ((busy_q & $past(kill_o) & ~$past(alloc_oh_i)) == '0));
  a_r5_slot_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_hit_o && !res_mispred_i && !(|(alloc_oh_i & res_bit_o))) |=> !(|(busy_q & $past(res_bit_o))));
endmodule

// File: rtl/spec_entry_window.sv
module spec_entry_window #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned WIN_DEPTH = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [IDX_W-1:0]     issue_idx_i,
  input  logic [NUM_SLOTS-1:0] issue_mask_i,
  input  logic                 res_hit_i,
  input  logic                 res_mispred_i,
  input  logic [NUM_SLOTS-1:0] res_bit_i,
  input  logic [NUM_SLOTS-1:0] kill_i,
  output logic [NUM_SLOTS-1:0] mask_o [WIN_DEPTH],
  output logic [WIN_DEPTH-1:0] valid_o,
  output logic [WIN_DEPTH-1:0] abort_o
);
  logic [WIN_DEPTH-1:0] squash;
  logic [NUM_SLOTS-1:0] bit_present;

  for (genvar i = 0; i < WIN_DEPTH; i++) begin : g_ent
    logic wr;
    assign wr        = issue_i && (issue_idx_i == IDX_W'(i));
    assign squash[i] = res_hit_i && res_mispred_i && valid_o[i] && |(mask_o[i] & res_bit_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        mask_o[i]  <= '0;
        abort_o[i] <= 1'b0;
      end else begin
        abort_o[i] <= squash[i];
        // a new issue into the slot overrides the squash of its old occupant
        if (wr) begin
          valid_o[i] <= 1'b1;
          mask_o[i]  <= issue_mask_i;
        end else begin
          if (squash[i]) valid_o[i] <= 1'b0;
          mask_o[i] <= mask_o[i] & ~kill_i;
        end
      end
    end
  end

  always_comb begin
    bit_present = '0;
    for (int i = 0; i < WIN_DEPTH; i++)
      if (valid_o[i]) bit_present = bit_present | mask_o[i];
  end

  a_r6_abort_after_mispred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_o) |-> $past(res_hit_i && res_mispred_i));
  a_r5_bit_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_hit_i && !res_mispred_i) |=> !(|(bit_present & $past(res_bit_i))));
endmodule

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker
  import spec_tag_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = DEF_SLOTS,
  parameter int unsigned WIN_DEPTH = DEF_WIN,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned IDX_W    = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 br_req_i,
  output logic                 br_gnt_o,
  output logic [SLOT_W-1:0]    br_slot_o,
  input  logic                 issue_i,
  input  logic [IDX_W-1:0]     issue_idx_i,
  input  logic                 res_valid_i,
  input  logic [SLOT_W-1:0]    res_slot_i,
  input  logic                 res_mispred_i,
  output logic [NUM_SLOTS-1:0] active_mask_o,
  output logic [WIN_DEPTH-1:0] abort_vec_o,
  output logic [WIN_DEPTH-1:0] entry_valid_o,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [NUM_SLOTS-1:0] rd_mask_o
);
  logic [NUM_SLOTS-1:0] busy_post, kill, res_bit, alloc_oh;
  logic                 res_hit;
  logic [NUM_SLOTS-1:0] masks [WIN_DEPTH];

  spec_slot_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_table (
    .clk_i, .rst_ni,
    .res_valid_i, .res_slot_i, .res_mispred_i,
    .alloc_oh_i (alloc_oh),
    .busy_o     (active_mask_o),
    .busy_post_o(busy_post),
    .kill_o     (kill),
    .res_bit_o  (res_bit),
    .res_hit_o  (res_hit)
  );

  spec_slot_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_alloc (
    .clk_i, .rst_ni,
    .req_i      (br_req_i),
    .busy_post_i(busy_post),
    .oh_o       (alloc_oh),
    .gnt_o      (br_gnt_o),
    .slot_o     (br_slot_o)
  );

  spec_entry_window #(.NUM_SLOTS(NUM_SLOTS), .WIN_DEPTH(WIN_DEPTH), .IDX_W(IDX_W)) u_win (
    .clk_i, .rst_ni,
    .issue_i, .issue_idx_i,
    .issue_mask_i (busy_post),
    .res_hit_i    (res_hit),
    .res_mispred_i,
    .res_bit_i    (res_bit),
    .kill_i       (kill),
    .mask_o       (masks),
    .valid_o      (entry_valid_o),
    .abort_o      (abort_vec_o)
  );

  always_comb begin
    rd_mask_o = '0;
    for (int i = 0; i < WIN_DEPTH; i++)
      if (rd_idx_i == IDX_W'(i)) rd_mask_o = masks[i];
  end

  a_r2_granted_slot_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_gnt_o |-> active_mask_o[br_slot_o]);
endmodule

// File: tb/sim_spec_tag_tracker.sv
`timescale 1ns/1ps
module sim_spec_tag_tracker;
  localparam int NS = 4;
  localparam int NW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic br_req = 0, issue = 0, res_v = 0, res_m = 0;
  logic [1:0] res_s = 0, br_slot;
  logic [2:0] issue_idx = 0, rd_idx = 0;
  logic br_gnt;
  logic [3:0] active, rd_mask;
  logic [7:0] abort_vec, ev_o;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  spec_tag_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .br_req_i(br_req), .br_gnt_o(br_gnt), .br_slot_o(br_slot),
    .issue_i(issue), .issue_idx_i(issue_idx), .res_valid_i(res_v), .res_slot_i(res_s),
    .res_mispred_i(res_m), .active_mask_o(active), .abort_vec_o(abort_vec),
    .entry_valid_o(ev_o), .rd_idx_i(rd_idx), .rd_mask_o(rd_mask)
  );

  // behavioural reference
  int m_busy, m_dep[NS], m_em[NW], m_ev, m_abort, m_gnt, m_slot;

  task automatic m_reset();
    m_busy = 0; m_ev = 0; m_abort = 0; m_gnt = 0; m_slot = 0;
    for (int k = 0; k < NS; k++) m_dep[k] = 0;
    for (int i = 0; i < NW; i++) m_em[i] = 0;
  endtask

  task automatic m_step();
    int kill, rbit, abort_n;
    bit hit, found;
    kill = 0; abort_n = 0; rbit = 1 << res_s;
    hit = res_v && ((m_busy & rbit) != 0);
    if (hit) begin
      kill = rbit;
      if (res_m)
        for (int k = 0; k < NS; k++)
          if (((m_busy >> k) & 1) && (m_dep[k] & rbit)) kill |= (1 << k);
    end
    for (int i = 0; i < NW; i++) begin
      if (hit && res_m && ((m_ev >> i) & 1) && (m_em[i] & rbit)) begin
        abort_n |= (1 << i);
        m_ev &= ~(1 << i);
      end else m_em[i] &= ~kill;
    end
    for (int k = 0; k < NS; k++) m_dep[k] &= ~kill;
    m_busy &= ~kill;
    m_abort = abort_n;
    m_gnt = 0;
    found = 0;
    if (br_req)
      for (int k = 0; k < NS; k++)
        if (!found && !((m_busy >> k) & 1)) begin
          found = 1; m_gnt = 1; m_slot = k;
          m_dep[k] = m_busy;
        end
    if (issue) begin
      m_em[issue_idx] = m_busy;
      m_ev |= (1 << issue_idx);
    end
    if (m_gnt) m_busy |= (1 << m_slot);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(br_gnt == m_gnt, "R2/R3 grant", br_gnt, m_gnt);
    if (m_gnt) chk(br_slot == m_slot[1:0], "R2 slot", br_slot, m_slot);
    chk(active == m_busy[3:0], "R1/R5/R7 active", active, m_busy);
    chk(abort_vec == m_abort[7:0], "R6 abort", abort_vec, m_abort);
    chk(ev_o == m_ev[7:0], "R6 valid", ev_o, m_ev);
    for (int i = 0; i < NW; i++) begin
      rd_idx = 3'(i);
      #0.05;
      if ((m_ev >> i) & 1) chk(rd_mask == m_em[i][3:0], "R4/R5 mask", rd_mask, m_em[i]);
    end
  endtask

  task automatic step(input bit rq, input bit rv, input int rs, input bit rm,
                      input bit iv, input int ii);
    br_req = rq; res_v = rv; res_s = 2'(rs); res_m = rm; issue = iv; issue_idx = 3'(ii);
    m_step();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic mask_at(input int i, input int exp, input string tag);
    rd_idx = 3'(i);
    #0.05;
    chk(rd_mask == exp[3:0], tag, rd_mask, exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(active == 0 && br_gnt == 0, "R10 reset slots", active, 0);
    chk(ev_o == 0 && abort_vec == 0, "R10 reset window", {ev_o, abort_vec}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // fill all slots, issuing under each
    for (int k = 0; k < NS; k++) begin
      step(1, 0, 0, 0, 1, k);
      chk(br_gnt && br_slot == 2'(k), "R2 lowest free", br_slot, k);
    end
    step(1, 0, 0, 0, 1, 4);
    chk(!br_gnt && active == 4'hf, "R3 refused when full", {br_gnt, active}, 15);
    mask_at(3, 4'h7, "R4 inherited mask");
    mask_at(4, 4'hf, "R4 full mask");
    step(0, 1, 0, 0, 0, 0);
    chk(active == 4'he, "R5 slot freed", active, 14);
    mask_at(4, 4'he, "R5 bit cleared");
    mask_at(1, 4'h0, "R5 bit cleared");
    // mispredict slot 2 with same-cycle allocation
    step(1, 1, 2, 1, 0, 0);
    chk(abort_vec == 8'h18, "R6 abort vector", abort_vec, 8'h18);
    chk(ev_o == 8'h07, "R6 entries invalidated", ev_o, 8'h07);
    chk(br_gnt && br_slot == 0, "R8 resolve before alloc", br_slot, 0);
    chk(active == 4'h3, "R7 younger slot freed", active, 3);
    step(0, 0, 0, 0, 0, 0);
    chk(abort_vec == 0, "R6 single-cycle pulse", abort_vec, 0);
    step(0, 1, 3, 1, 0, 0);
    chk(active == 4'h3 && ev_o == 8'h07 && abort_vec == 0, "R9 idle slot ignored",
        {active, ev_o}, 12'h307);
    // random traffic against the model
    for (int n = 0; n < 4000; n++)
      step(($urandom % 3) == 0, ($urandom % 4) == 0, int'($urandom % NS), ($urandom % 3) == 0,
           ($urandom % 2) == 0, int'($urandom % NW));
    rst_ni = 1'b0;
    m_reset();
    #1;
    chk(active == 0 && ev_o == 0 && abort_vec == 0 && !br_gnt, "R10 async reset", active, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule